// File: doc/BRIEF.md
# I2C Multi-Message Master Sequencer

This block runs a combined I2C transaction made of up to `MAX_MSG` message descriptors. It drives a byte-level I2C engine through single-cycle commands (START, STOP, NAK, send byte or receive byte) and reacts to that engine's completion events. Each descriptor gives a 7-bit target address, a direction, a byte count and a flag that joins the message to the one before it without a new address. Bit timing on SCL and SDA and clock stretching are the engine's job. The sequencer decides what each command carries: an address byte, a data byte from a local buffer, STOP on the final byte, and ACK or NAK for received bytes.

Bytes to send and bytes received share one buffer. Successive messages use successive locations, starting at location 0. A host fills the buffer before a run and reads it back afterwards. A run waits for the bus to be idle before its first START. If the very first address byte is NAKed, the whole list is retried up to `RETRIES` more times. Any other NAK ends the run with an error. A zero-length message works as a device probe. Two cycle-count limits turn a stuck bus or a silent engine into a timeout status.

Top module: `i2c_msg_seq`

## Requirements
- R1: The first command of every attempt has START and send set, STOP and NAK clear, and carries the address byte {addr[6:0], rd}, where rd is 1 for a read and 0 for a write.
- R2: No command is issued while unit_busy or bus_busy is high, or while scl_mon or sda_mon is low. The first START follows once all four show an idle bus.
- R3: In a write message, each byte is sent with a send command whose data comes from the next buffer location, in order. Only the final byte of the final message carries STOP.
- R4: In a read message, each byte is requested with a receive command (send clear, data 0). STOP and NAK are both set only for the final byte of the final message. Received bytes are stored in the next buffer locations, in order.
- R5: When a message ends and more remain, the next message begins with a START command carrying that message's address byte. If its continue flag is set, its bytes follow at once with no address and in the direction of the message before it.
- R6: A NAK on the first address byte of an attempt restarts the whole list from message 0 and buffer location 0. After `RETRIES` restarts, a further NAK ends the run with status error.
- R7: A NAK on any data byte, or on a repeated-START address, ends the run at once with status error, with no retry and no further command.
- R8: A message of length 0 ends the run with status OK as soon as its address is ACKed. eng_rst pulses in the same cycle as done.
- R9: ev_arb_lost does not change the command sequence or the status. It sets arb_seen, which go clears.
- R10: A run still waiting for an idle bus after `FREE_TMO` cycles ends with status timeout, with done 2 cycles after the limit counted from go. A run not finished `TXN_TMO` cycles after go also ends with status timeout.
- R11: done is a one-cycle pulse, and status holds its value until the next run. The codes are 0 OK, 1 error and 2 timeout. busy is high from the cycle after go until done.
- R12: Descriptor i occupies desc_flat[i*(9+LEN_W) +: 9+LEN_W]. Within it, bits [6:0] hold the address, bit 7 is read, bit 8 is continue, and bits [8+LEN_W:9] hold the length. msg_count gives the number of messages in use.
- R13: After reset, busy, done and cmd_go are 0 and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a run (accepted while idle) |
| msg_count | input | CNT_W | Number of descriptors used (1..MAX_MSG) |
| desc_flat | input | MAX_MSG*DESC_W | Packed descriptors |
| host_wr_en | input | 1 | Host buffer write |
| host_wr_addr | input | AW | Host write location |
| host_wr_data | input | 8 | Host write byte |
| host_rd_addr | input | AW | Host read location |
| host_rd_data | output | 8 | Host read byte, one cycle after the address |
| unit_busy | input | 1 | Engine reports it is busy |
| bus_busy | input | 1 | Engine reports the bus is busy |
| scl_mon | input | 1 | Sampled SCL level |
| sda_mon | input | 1 | Sampled SDA level |
| ev_tx_done | input | 1 | Engine finished sending a byte |
| ev_nak | input | 1 | The byte just sent was NAKed |
| ev_rx_done | input | 1 | Engine finished receiving a byte |
| ev_rx_data | input | 8 | Received byte |
| ev_arb_lost | input | 1 | Arbitration-lost indication |
| cmd_go | output | 1 | Command strobe |
| cmd_start | output | 1 | Generate (repeated) START before the byte |
| cmd_stop | output | 1 | Generate STOP after the byte |
| cmd_nak | output | 1 | Answer the received byte with NAK |
| cmd_write | output | 1 | 1 send cmd_data, 0 receive a byte |
| cmd_data | output | 8 | Byte to send |
| eng_rst | output | 1 | Engine reset pulse after a probe |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one cycle) |
| status | output | 2 | Final status |
| arb_seen | output | 1 | Arbitration loss seen during this run |

## Verification
The main function is swept over every single-message case (both directions, lengths 0 to 3) and every two-message case (each direction pair, continue flag on and off, lengths 1 and 2). Three-message cases cover all direction patterns, with and without a joined third message. These sweeps separate the addressing of a repeated START from a continuation, and STOP placement from NAK placement, and they show whether received bytes land at the right buffer offsets.

Separate runs cover other behaviour:
- NAK patterns on the first address, on a data byte and on a repeated-START address, which separate a retry from an immediate error and show where retries run out.
- Each bus-busy condition held in turn, together with exact-cycle checks of both timeouts.
- An arbitration-loss pulse in the middle of a run.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_ERR = 2'd1, ST_TMO = 2'd2} seq_status_e;
  typedef enum logic [2:0] {S_IDLE, S_WFREE, S_ADDR, S_FETCH, S_SEND, S_DWAIT} seq_state_e;

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction
endpackage

// File: rtl/i2cseq_buf.sv
module i2cseq_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rda_addr,
  output logic [7:0]    rda_data,
  input  logic [AW-1:0] rdb_addr,
  output logic [7:0]    rdb_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rda_data <= mem[rda_addr];
    rdb_data <= mem[rdb_addr];
  end
endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
  parameter int LIMIT = 64,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt == W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R10: once reached, the limit stays reached until cleared
  a_r10_timer_holds: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/i2cseq_ctl.sv
module i2cseq_ctl import i2cseq_pkg::*; #(
  parameter int MAX_MSG = 4,
  parameter int LEN_W   = 4,
  parameter int AW      = 4,
  parameter int RETRIES = 2,
  localparam int IDX_W  = (MAX_MSG > 1) ? $clog2(MAX_MSG) : 1,
  localparam int CNT_W  = $clog2(MAX_MSG + 1),
  localparam int DESC_W = 9 + LEN_W,
  localparam int RT_W   = (RETRIES > 0) ? $clog2(RETRIES + 1) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic [CNT_W-1:0]          msg_count,
  input  logic [MAX_MSG*DESC_W-1:0] desc_flat,
  input  logic                      unit_busy,
  input  logic                      bus_busy,
  input  logic                      scl_mon,
  input  logic                      sda_mon,
  input  logic                      ev_tx_done,
  input  logic                      ev_nak,
  input  logic                      ev_rx_done,
  input  logic [7:0]                ev_rx_data,
  input  logic                      ev_arb_lost,
  input  logic [7:0]                rdata,
  input  logic                      free_exp,
  input  logic                      txn_exp,
  output logic                      free_clr,
  output logic                      txn_clr,
  output logic [AW-1:0]             ptr,
  output logic                      seq_wr_en,
  output logic [7:0]                seq_wr_data,
  output logic                      cmd_go,
  output logic                      cmd_start,
  output logic                      cmd_stop,
  output logic                      cmd_nak,
  output logic                      cmd_write,
  output logic [7:0]                cmd_data,
  output logic                      eng_rst,
  output logic                      busy,
  output logic                      done,
  output seq_status_e               status,
  output logic                      arb_seen
);
  seq_state_e       st;
  logic [IDX_W-1:0] idx, nidx;
  logic [LEN_W-1:0] bcnt, cur_len;
  logic [6:0]       cur_addr, nxt_addr;
  logic             cur_rd, nxt_rd, nxt_ns;
  logic             dir, first, free_now, last_msg, last_byte, fin_byte, byte_evt;
  logic [RT_W-1:0]  tries;

  assign nidx = idx + 1'b1;

  always_comb begin
    cur_addr = desc_flat[int'(idx)*DESC_W +: 7];
    cur_rd   = desc_flat[int'(idx)*DESC_W + 7];
    cur_len  = desc_flat[int'(idx)*DESC_W + 9 +: LEN_W];
    nxt_addr = desc_flat[int'(nidx)*DESC_W +: 7];
    nxt_rd   = desc_flat[int'(nidx)*DESC_W + 7];
    nxt_ns   = desc_flat[int'(nidx)*DESC_W + 8];
  end

  assign free_now  = !unit_busy && !bus_busy && scl_mon && sda_mon;
  assign last_msg  = ((CNT_W'(idx) + CNT_W'(1)) == msg_count);
  assign last_byte = (bcnt == cur_len - 1'b1);
  assign fin_byte  = last_msg && last_byte;
  assign byte_evt  = (st == S_DWAIT) && (dir ? ev_rx_done : ev_tx_done);

  assign free_clr    = (st != S_WFREE);
  assign txn_clr     = (st == S_IDLE);
  assign seq_wr_en   = (st == S_DWAIT) && dir && ev_rx_done;
  assign seq_wr_data = ev_rx_data;

  always_ff @(posedge clk) begin
    cmd_go  <= 1'b0;
    done    <= 1'b0;
    eng_rst <= 1'b0;
    if (rst) begin
      st <= S_IDLE; busy <= 1'b0; status <= ST_OK; arb_seen <= 1'b0;
      idx <= '0; bcnt <= '0; ptr <= '0; dir <= 1'b0; first <= 1'b0; tries <= '0;
      cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_nak <= 1'b0;
      cmd_write <= 1'b0; cmd_data <= '0;
    end else begin
      if (busy && ev_arb_lost) arb_seen <= 1'b1;
      if (busy && txn_exp) begin
        busy <= 1'b0; done <= 1'b1; status <= ST_TMO; st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (go) begin
            busy <= 1'b1; arb_seen <= 1'b0; tries <= '0;
            idx <= '0; bcnt <= '0; ptr <= '0; first <= 1'b1; st <= S_WFREE;
          end
          S_WFREE: begin
            if (free_now) begin
              cmd_go <= 1'b1; cmd_start <= 1'b1; cmd_stop <= 1'b0; cmd_nak <= 1'b0;
              cmd_write <= 1'b1; cmd_data <= addr_byte(cur_addr, cur_rd);
              dir <= cur_rd; st <= S_ADDR;
            end else if (free_exp) begin
              busy <= 1'b0; done <= 1'b1; status <= ST_TMO; st <= S_IDLE;
            end
          end
          S_ADDR: if (ev_tx_done) begin
            if (ev_nak) begin
              if (first && (tries < RT_W'(RETRIES))) begin
                tries <= tries + 1'b1;
                idx <= '0; bcnt <= '0; ptr <= '0; st <= S_WFREE;
              end else begin
                busy <= 1'b0; done <= 1'b1; status <= ST_ERR; st <= S_IDLE;
              end
            end else begin
              first <= 1'b0;
              if (cur_len == '0) begin
                eng_rst <= 1'b1;
                busy <= 1'b0; done <= 1'b1; status <= ST_OK; st <= S_IDLE;
              end else begin
                st <= S_FETCH;
              end
            end
          end
          S_FETCH: st <= S_SEND;
          S_SEND: begin
            cmd_go <= 1'b1; cmd_start <= 1'b0;
            cmd_write <= !dir;
            cmd_data <= dir ? 8'h00 : rdata;
            cmd_stop <= fin_byte;
            cmd_nak <= dir && fin_byte;
            st <= S_DWAIT;
          end
          S_DWAIT: if (byte_evt) begin
            if (!dir && ev_nak) begin
              busy <= 1'b0; done <= 1'b1; status <= ST_ERR; st <= S_IDLE;
            end else begin
              ptr <= ptr + 1'b1;
              if (!last_byte) begin
                bcnt <= bcnt + 1'b1; st <= S_FETCH;
              end else if (last_msg) begin
                busy <= 1'b0; done <= 1'b1; status <= ST_OK; st <= S_IDLE;
              end else begin
                idx <= nidx; bcnt <= '0;
                if (nxt_ns) begin
                  st <= S_FETCH;
                end else begin
                  cmd_go <= 1'b1; cmd_start <= 1'b1; cmd_stop <= 1'b0; cmd_nak <= 1'b0;
                  cmd_write <= 1'b1; cmd_data <= addr_byte(nxt_addr, nxt_rd);
                  dir <= nxt_rd; st <= S_ADDR;
                end
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2: no command follows a cycle in which the bus looked busy while waiting
  a_r2_wait_for_idle_bus: assert property (@(posedge clk) disable iff (rst)
    (st == S_WFREE && !free_now) |=> !cmd_go);
  // R1/R5: an address command never carries STOP and always sends
  a_r1_start_is_send: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_start) |-> (cmd_write && !cmd_stop && !cmd_nak));
  // R4: NAK is only requested on a final receive that also stops
  a_r4_nak_with_stop: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_nak) |-> (cmd_stop && !cmd_write));
  // R8: the probe reset comes with a successful completion
  a_r8_probe_reset: assert property (@(posedge clk) disable iff (rst)
    eng_rst |-> (done && status == ST_OK && !busy));
  // R11: done lasts one cycle and commands only occur during a run
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_cmd_in_run: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> busy);
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq import i2cseq_pkg::*; #(
  parameter int MAX_MSG   = 4,
  parameter int LEN_W     = 4,
  parameter int BUF_DEPTH = 16,
  parameter int RETRIES   = 2,
  parameter int FREE_TMO  = 64,
  parameter int TXN_TMO   = 4096,
  localparam int AW     = $clog2(BUF_DEPTH),
  localparam int CNT_W  = $clog2(MAX_MSG + 1),
  localparam int DESC_W = 9 + LEN_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic [CNT_W-1:0]          msg_count,
  input  logic [MAX_MSG*DESC_W-1:0] desc_flat,
  input  logic                      host_wr_en,
  input  logic [AW-1:0]             host_wr_addr,
  input  logic [7:0]                host_wr_data,
  input  logic [AW-1:0]             host_rd_addr,
  output logic [7:0]                host_rd_data,
  input  logic                      unit_busy,
  input  logic                      bus_busy,
  input  logic                      scl_mon,
  input  logic                      sda_mon,
  input  logic                      ev_tx_done,
  input  logic                      ev_nak,
  input  logic                      ev_rx_done,
  input  logic [7:0]                ev_rx_data,
  input  logic                      ev_arb_lost,
  output logic                      cmd_go,
  output logic                      cmd_start,
  output logic                      cmd_stop,
  output logic                      cmd_nak,
  output logic                      cmd_write,
  output logic [7:0]                cmd_data,
  output logic                      eng_rst,
  output logic                      busy,
  output logic                      done,
  output logic [1:0]                status,
  output logic                      arb_seen
);
  logic          free_clr, txn_clr, free_exp, txn_exp, seq_wr_en, wr_en;
  logic [AW-1:0] ptr, wr_addr;
  logic [7:0]    seq_wr_data, wr_data, rdata;
  seq_status_e   st_code;

  assign wr_en   = seq_wr_en || host_wr_en;
  assign wr_addr = seq_wr_en ? ptr : host_wr_addr;
  assign wr_data = seq_wr_en ? seq_wr_data : host_wr_data;
  assign status  = st_code;

  i2cseq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rda_addr(host_rd_addr), .rda_data(host_rd_data),
    .rdb_addr(ptr), .rdb_data(rdata));

  i2cseq_timer #(.LIMIT(FREE_TMO)) u_free_tmr (
    .clk(clk), .rst(rst), .clr(free_clr), .expired(free_exp));

  i2cseq_timer #(.LIMIT(TXN_TMO)) u_txn_tmr (
    .clk(clk), .rst(rst), .clr(txn_clr), .expired(txn_exp));

  i2cseq_ctl #(.MAX_MSG(MAX_MSG), .LEN_W(LEN_W), .AW(AW), .RETRIES(RETRIES)) u_ctl (
    .clk(clk), .rst(rst), .go(go), .msg_count(msg_count), .desc_flat(desc_flat),
    .unit_busy(unit_busy), .bus_busy(bus_busy), .scl_mon(scl_mon), .sda_mon(sda_mon),
    .ev_tx_done(ev_tx_done), .ev_nak(ev_nak), .ev_rx_done(ev_rx_done),
    .ev_rx_data(ev_rx_data), .ev_arb_lost(ev_arb_lost), .rdata(rdata),
    .free_exp(free_exp), .txn_exp(txn_exp), .free_clr(free_clr), .txn_clr(txn_clr),
    .ptr(ptr), .seq_wr_en(seq_wr_en), .seq_wr_data(seq_wr_data),
    .cmd_go(cmd_go), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_nak(cmd_nak),
    .cmd_write(cmd_write), .cmd_data(cmd_data), .eng_rst(eng_rst),
    .busy(busy), .done(done), .status(st_code), .arb_seen(arb_seen));
endmodule

// File: tb/sim_i2c_msg_seq.sv
module sim_i2c_msg_seq;
  localparam int CLK_NS = 10;
  localparam int MAX_MSG = 4, LEN_W = 4, BUF_DEPTH = 16, RETRIES = 2;
  localparam int FREE_TMO = 40, TXN_TMO = 400;
  localparam int AW = 4, CNT_W = 3, DESC_W = 9 + LEN_W;

  logic clk = 0, rst = 1, go = 0;
  logic [CNT_W-1:0] msg_count = '0;
  logic [MAX_MSG*DESC_W-1:0] desc_flat = '0;
  logic host_wr_en = 0;
  logic [AW-1:0] host_wr_addr = '0, host_rd_addr = '0;
  logic [7:0] host_wr_data = '0, host_rd_data;
  logic unit_busy = 0, bus_busy = 0, scl_mon = 1, sda_mon = 1;
  logic ev_tx_done = 0, ev_nak = 0, ev_rx_done = 0, ev_arb_lost = 0;
  logic [7:0] ev_rx_data = '0;
  logic cmd_go, cmd_start, cmd_stop, cmd_nak, cmd_write, eng_rst, busy, done, arb_seen;
  logic [7:0] cmd_data;
  logic [1:0] status;

  i2c_msg_seq #(.MAX_MSG(MAX_MSG), .LEN_W(LEN_W), .BUF_DEPTH(BUF_DEPTH), .RETRIES(RETRIES),
                .FREE_TMO(FREE_TMO), .TXN_TMO(TXN_TMO)) u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc_all = 0;

  // scenario description
  int n_msg; logic [6:0] d_addr[4]; bit d_rd[4], d_ns[4]; int d_len[4]; int seed;
  // expected results
  bit e_start[64], e_stop[64], e_nak[64], e_wr[64]; logic [7:0] e_data[64]; int e_n;
  logic [7:0] e_buf[16]; int e_rst;
  // engine model state and log
  bit l_start[64], l_stop[64], l_nak[64], l_wr[64]; logic [7:0] l_data[64]; int l_n = 0;
  bit nak_mask[64]; int rx_k = 0, rst_seen = 0, lat = 1; bit mute = 0;
  bit pend = 0, pw = 0, pn = 0; int dly = 0;

  function automatic logic [7:0] rxv(int k); return 8'(90 + k*3); endfunction
  function automatic logic [7:0] prev(int a, int s); return 8'(a*13 + 7 + s*29); endfunction

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc_all);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // byte engine model, driven away from the active edge
  always @(negedge clk) begin
    ev_tx_done = 0; ev_rx_done = 0; ev_nak = 0;
    if (eng_rst) rst_seen++;
    if (pend) begin
      if (dly > 0) dly--;
      else begin
        pend = 0;
        if (pw) begin ev_tx_done = 1; ev_nak = pn; end
        else begin ev_rx_done = 1; ev_rx_data = rxv(rx_k); rx_k++; end
      end
    end
    if (cmd_go && l_n < 64) begin
      l_start[l_n] = cmd_start; l_stop[l_n] = cmd_stop; l_nak[l_n] = cmd_nak;
      l_wr[l_n] = cmd_write; l_data[l_n] = cmd_data;
      if (!mute) begin pend = 1; dly = lat; pw = cmd_write; pn = nak_mask[l_n]; end
      l_n++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_expected();
    int p = 0, k = 0; bit dir = 0; bit stopped = 0;
    e_n = 0; e_rst = 0;
    for (int a = 0; a < 16; a++) e_buf[a] = prev(a, seed);
    for (int i = 0; i < n_msg && !stopped; i++) begin
      if (i == 0 || !d_ns[i]) begin
        e_start[e_n] = 1; e_stop[e_n] = 0; e_nak[e_n] = 0; e_wr[e_n] = 1;
        e_data[e_n] = {d_addr[i], d_rd[i]}; e_n++;
        dir = d_rd[i];
        if (d_len[i] == 0) begin e_rst = 1; stopped = 1; end
      end
      for (int j = 0; j < d_len[i] && !stopped; j++) begin
        bit fin = (i == n_msg-1) && (j == d_len[i]-1);
        e_start[e_n] = 0; e_stop[e_n] = fin; e_nak[e_n] = fin && dir; e_wr[e_n] = !dir;
        e_data[e_n] = dir ? 8'h00 : prev(p, seed); e_n++;
        if (dir) begin e_buf[p] = rxv(k); k++; end
        p++;
      end
    end
  endtask

  task automatic start_case();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); host_wr_en = 1; host_wr_addr = 4'(a); host_wr_data = prev(a, seed);
    end
    @(negedge clk); host_wr_en = 0;
    desc_flat = '0;
    for (int i = 0; i < n_msg; i++)
      desc_flat[i*DESC_W +: DESC_W] = {4'(d_len[i]), d_ns[i], d_rd[i], d_addr[i]};
    msg_count = 3'(n_msg);
    l_n = 0; rx_k = 0; rst_seen = 0;
    build_expected();
    go = 1; @(negedge clk); go = 0;
  endtask

  task automatic wait_done(string req);
    int c = 0;
    while (!done && c < 3000) begin @(negedge clk); c++; end
    chk(done, req, "done never seen", 0, 1);
  endtask

  task automatic full_check(string req);
    wait_done(req);
    chk(status == 2'd0, req, "status", status, 0);
    @(negedge clk);
    chk(l_n == e_n, req, "command count", l_n, e_n);
    for (int i = 0; i < e_n && i < l_n; i++) begin
      chk(l_start[i] == e_start[i], req, "cmd start", l_start[i], e_start[i]);
      chk(l_stop[i] == e_stop[i], req, "cmd stop", l_stop[i], e_stop[i]);
      chk(l_nak[i] == e_nak[i], req, "cmd nak", l_nak[i], e_nak[i]);
      chk(l_wr[i] == e_wr[i], req, "cmd write", l_wr[i], e_wr[i]);
      chk(l_data[i] == e_data[i], req, "cmd data", l_data[i], e_data[i]);
    end
    chk(rst_seen == e_rst, "R8", "engine reset pulses", rst_seen, e_rst);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); host_rd_addr = 4'(a);
      @(negedge clk);
      chk(host_rd_data == e_buf[a], req, "buffer byte", host_rd_data, e_buf[a]);
    end
  endtask

  task automatic clear_desc();
    for (int i = 0; i < 4; i++) begin
      d_addr[i] = 7'(7'h48 + i*5); d_rd[i] = 0; d_ns[i] = 0; d_len[i] = 1;
    end
    for (int i = 0; i < 64; i++) nak_mask[i] = 0;
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(busy == 0 && done == 0 && cmd_go == 0, "R13", "idle outputs", {busy, done, cmd_go}, 0);
    chk(status == 2'd0, "R13", "reset status", status, 0);

    // single messages: R1 R3 R4 R8
    seed = 0;
    for (int rd = 0; rd < 2; rd++)
      for (int ln = 0; ln < 4; ln++) begin
        clear_desc(); seed++; n_msg = 1; d_rd[0] = rd; d_len[0] = ln;
        start_case();
        full_check(ln == 0 ? "R8" : (rd ? "R4" : "R3"));
        chk(arb_seen == 0, "R9", "arb_seen without loss", arb_seen, 0);
      end

    // two messages, restart vs continuation: R5
    for (int m = 0; m < 32; m++) begin
      clear_desc(); seed++; n_msg = 2;
      d_rd[0] = m[0]; d_rd[1] = m[1]; d_ns[1] = m[2];
      d_len[0] = 1 + m[3]; d_len[1] = 1 + m[4];
      start_case(); full_check("R5");
    end

    // three messages: R5 R12
    for (int m = 0; m < 16; m++) begin
      clear_desc(); seed++; n_msg = 3;
      d_rd[0] = m[0]; d_rd[1] = m[1]; d_rd[2] = m[2]; d_ns[2] = m[3];
      d_len[0] = 2; d_len[1] = 1; d_len[2] = 3;
      start_case(); full_check("R12");
    end

    // retry then success: R6
    clear_desc(); seed++; n_msg = 1; d_len[0] = 2; nak_mask[0] = 1; nak_mask[1] = 1;
    start_case(); wait_done("R6");
    chk(status == 2'd0, "R6", "status after two retries", status, 0);
    @(negedge clk);
    chk(l_n == 5, "R6", "commands with retries", l_n, 5);
    chk(l_start[1] && l_data[1] == {d_addr[0], 1'b0}, "R6", "retry re-addresses", l_data[1], {d_addr[0], 1'b0});
    chk(l_data[3] == prev(0, seed), "R6", "retry restarts buffer", l_data[3], prev(0, seed));

    // retries exhausted: R6
    clear_desc(); seed++; n_msg = 1; d_len[0] = 2;
    nak_mask[0] = 1; nak_mask[1] = 1; nak_mask[2] = 1;
    start_case(); wait_done("R6");
    chk(status == 2'd1, "R6", "status after exhaustion", status, 1);
    @(negedge clk);
    chk(l_n == 3, "R6", "commands when exhausted", l_n, 3);

    // data NAK: R7
    clear_desc(); seed++; n_msg = 1; d_len[0] = 3; nak_mask[1] = 1;
    start_case(); wait_done("R7");
    chk(status == 2'd1, "R7", "status on data nak", status, 1);
    @(negedge clk);
    chk(l_n == 2, "R7", "commands on data nak", l_n, 2);

    // repeated-start address NAK: R7
    clear_desc(); seed++; n_msg = 2; nak_mask[2] = 1;
    start_case(); wait_done("R7");
    chk(status == 2'd1, "R7", "status on restart nak", status, 1);
    @(negedge clk);
    chk(l_n == 3, "R7", "no retry on restart nak", l_n, 3);

    // bus idle conditions: R2
    clear_desc(); seed++; n_msg = 1; d_len[0] = 1;
    bus_busy = 1;
    start_case();
    repeat (9) @(negedge clk);
    bus_busy = 0; unit_busy = 1; repeat (9) @(negedge clk);
    unit_busy = 0; scl_mon = 0; repeat (8) @(negedge clk);
    scl_mon = 1; sda_mon = 0; repeat (8) @(negedge clk);
    chk(l_n == 0, "R2", "commands while bus busy", l_n, 0);
    sda_mon = 1;
    full_check("R2");

    // bus-free timeout with exact cycle: R10
    clear_desc(); seed++; n_msg = 1;
    bus_busy = 1;
    for (int i = 0; i < 4; i++) d_len[i] = 1;
    msg_count = 3'd1; desc_flat[0 +: DESC_W] = {4'd1, 1'b0, 1'b0, d_addr[0]};
    l_n = 0;
    @(negedge clk); go = 1; c = 0;
    @(negedge clk); go = 0; c = 1;
    while (!done && c < 500) begin @(negedge clk); c++; end
    chk(c == FREE_TMO + 2, "R10", "bus-free timeout cycle", c, FREE_TMO + 2);
    chk(status == 2'd2, "R10", "bus-free timeout status", status, 2);
    chk(l_n == 0, "R10", "no command on timeout", l_n, 0);
    bus_busy = 0;

    // overall timeout with silent engine: R10
    mute = 1; l_n = 0;
    @(negedge clk); go = 1; c = 0;
    @(negedge clk); go = 0; c = 1;
    while (!done && c < 1000) begin @(negedge clk); c++; end
    chk(c == TXN_TMO + 2, "R10", "overall timeout cycle", c, TXN_TMO + 2);
    chk(status == 2'd2, "R10", "overall timeout status", status, 2);
    @(negedge clk);
    chk(done == 0, "R11", "done one cycle", done, 0);
    chk(status == 2'd2, "R11", "status held", status, 2);
    mute = 0;
    repeat (5) @(negedge clk);

    // arbitration loss ignored: R9
    clear_desc(); seed++; n_msg = 2; d_rd[1] = 1; d_len[0] = 2; d_len[1] = 2;
    start_case();
    repeat (4) @(negedge clk);
    chk(busy == 1, "R11", "busy during run", busy, 1);
    ev_arb_lost = 1; @(negedge clk); ev_arb_lost = 0;
    full_check("R9");
    chk(arb_seen == 1, "R9", "arb_seen after loss", arb_seen, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule